// File: doc/BRIEF.md
# Byte-Serial SPI Master Engine

This block is the data path of an SPI bus master. Software-side logic pushes bytes into a transmit queue. The engine selects one slave and shifts each byte out on the serial data line, most significant bit first. At the same time it shifts in one byte from the slave for every byte it sends, and that byte lands in a receive queue. Clock polarity, clock phase, a power-of-two clock divider and a chip-select code come from plain configuration inputs. A 32-bit gap word holds four 8-bit timing gaps, each counted in system clock cycles. The gaps cover chip-select setup, spacing between bytes, chip-select hold and the minimum time with no slave selected.

A single state machine sequences each burst. The states are `ST_IDLE`, `ST_LEAD` (chip select driven, setup gap running), `ST_SHIFT` (sixteen serial clock edges), `ST_GAP` (spacing between bytes, chip select held), `ST_TRAIL` (hold gap after the last byte) and `ST_DESEL` (no slave selected). The transitions are:
- IDLE→LEAD when the engine is enabled and a byte is queued.
- LEAD→SHIFT when the setup gap expires.
- SHIFT→GAP at the last edge of a byte if the engine is still enabled and another byte is queued.
- SHIFT→TRAIL at the last edge otherwise.
- GAP→SHIFT when the spacing gap expires.
- TRAIL→DESEL when the hold gap expires.
- DESEL→IDLE when the deselect gap expires.

Each gap state lasts its field value plus one cycle. The setup, spacing, hold and deselect gaps use `gap_cfg[7:0]`, `gap_cfg[23:16]`, `gap_cfg[15:8]` and `gap_cfg[31:24]` respectively.

Top module: `spi_xfer_engine`

## Requirements
- R1: Each byte taken from the transmit queue is sent MSB first on `mosi` as 8 bits. It produces exactly one byte in the receive queue: the 8 bits read on `miso`, MSB first.
- R2: Each queue holds 128 bytes. `tx_full` rises after 128 pushes. A push while `tx_full` is high is discarded: that byte is never sent.
- R3: With `baud_sel` = n for n from 1 to 7, each half period of `sclk` lasts 2^n clock cycles, so the divide ratio is 2^(n+1). The value 0 behaves as 1, giving a ratio of 4.
- R4: `sclk` rests at `clk_pol` whenever no slave is selected. Every byte takes exactly 16 `sclk` edges.
- R5: With `clk_pha`=0, `mosi` holds the first bit before the first edge and both sides sample on the 1st, 3rd, … edges. With `clk_pha`=1, data changes on those edges and is sampled on the 2nd, 4th, … edges.
- R6: The selected slave `i` is the position of the lowest 0 bit in `cs_field`; `ss_n[i]` is driven low during a burst. If that position is 3 or above, or the field is 4'hF, no line goes low and the bytes still shift. At most one line is ever low.
- R7: The first `sclk` edge comes `gap_cfg[7:0]` + 1 + 2^n cycles after `ss_n` falls.
- R8: Between bytes of one burst, `ss_n` stays low. The last edge of one byte and the first edge of the next are `gap_cfg[23:16]` + 1 + 2^n cycles apart.
- R9: `ss_n` rises `gap_cfg[15:8]` + 1 cycles after the last edge of a burst.
- R10: If a byte is queued while the hold gap runs, `ss_n` stays high for exactly `gap_cfg[31:24]` + 2 cycles before the next burst selects the slave.
- R11: While `xfer_en` is low, no burst starts. Clearing it during a byte lets that byte finish, then ends the burst, and the queued bytes stay queued until it is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en | input | 1 | Allows bursts to start and continue |
| clk_pol | input | 1 | Idle level of `sclk` |
| clk_pha | input | 1 | Sampling edge select |
| baud_sel | input | 3 | Divider exponent |
| cs_field | input | 4 | Active-low chip-select code |
| gap_cfg | input | 32 | Four 8-bit gap values |
| tx_push | input | 1 | Write strobe for the transmit queue |
| tx_byte | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Read strobe for the receive queue |
| rx_dout | output | 8 | Oldest received byte (shown before pop) |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| ss_n | output | 3 | Active-low slave selects |

## Verification
The hardest case to reach is the deselect gap while a byte is waiting. A byte must enter the transmit queue after the burst has committed to ending, but before chip select is released. The stimulus does this by pushing a second byte a few cycles after the slave model has counted the 16th edge, with a long hold gap that leaves room. The enable-cleared-mid-byte case needs a similar approach: the stimulus drops `xfer_en` right after the first `sclk` edge, with bytes still queued.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

    // Burst sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_TRAIL,
        ST_DESEL
    } xfer_state_t;

endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level;
    logic             do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
    parameter int SEL_W = 3,
    parameter int EDGES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     cpol,
    input  logic [SEL_W-1:0]         baud_sel,
    output logic                     sclk,
    output logic                     edge_stb,
    output logic [$clog2(EDGES)-1:0] edge_idx
);
    localparam int MAX_EXP = (1 << SEL_W) - 1;
    localparam int CNT_W   = MAX_EXP + 1;
    localparam int EW      = $clog2(EDGES);

    logic [SEL_W-1:0] half_exp;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] div_cnt;
    logic             phase_q;
    logic [EW-1:0]    idx_q;

    // Field value 0 is promoted to 1: the ratio never drops below 4
    assign half_exp = (baud_sel == '0) ? SEL_W'(1) : baud_sel;
    assign half_m1  = (CNT_W'(1) << half_exp) - CNT_W'(1);
    assign edge_stb = run && (div_cnt == half_m1);
    assign edge_idx = idx_q;
    assign sclk     = phase_q ^ cpol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            phase_q <= 1'b0;
            idx_q   <= '0;
        end else if (!run) begin
            div_cnt <= '0;
            phase_q <= 1'b0;
            idx_q   <= '0;
        end else if (edge_stb) begin
            div_cnt <= '0;
            phase_q <= ~phase_q;
            idx_q   <= idx_q + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int SEL_W      = 3,
    parameter int CS_W       = 4,
    parameter int NUM_SS     = 3,
    parameter int GAP_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_en,
    input  logic                clk_pol,
    input  logic                clk_pha,
    input  logic [SEL_W-1:0]    baud_sel,
    input  logic [CS_W-1:0]     cs_field,
    input  logic [4*GAP_W-1:0]  gap_cfg,
    input  logic                tx_push,
    input  logic [DATA_W-1:0]   tx_byte,
    output logic                tx_full,
    output logic                tx_empty,
    input  logic                rx_pop,
    output logic [DATA_W-1:0]   rx_dout,
    output logic                rx_empty,
    output logic                rx_full,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_SS-1:0]   ss_n
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    xfer_state_t        state_q, state_d;
    logic [GAP_W-1:0]   gap_cnt_q, gap_load;
    logic [GAP_W-1:0]   g_lead, g_hold, g_space, g_desel;
    logic [DATA_W-1:0]  tx_sr, rx_sr, rx_word, tx_head;
    logic               load_byte, rx_push;
    logic               cs_active, clk_run;
    logic               edge_stb, last_edge, sample_now, shift_now;
    logic [EW-1:0]      edge_idx;
    logic [NUM_SS-1:0]  slave_hit;
    logic               any_slave;

    assign g_lead  = gap_cfg[GAP_W-1:0];
    assign g_hold  = gap_cfg[2*GAP_W-1:GAP_W];
    assign g_space = gap_cfg[3*GAP_W-1:2*GAP_W];
    assign g_desel = gap_cfg[4*GAP_W-1:3*GAP_W];

    spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(tx_byte),
        .pop(load_byte), .dout(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty)
    );

    spi_sclk_gen #(.SEL_W(SEL_W), .EDGES(EDGES)) sclk_i (
        .clk(clk), .rst_n(rst_n),
        .run(clk_run), .cpol(clk_pol), .baud_sel(baud_sel),
        .sclk(sclk), .edge_stb(edge_stb), .edge_idx(edge_idx)
    );

    // Edge classification: leading edges have even index
    assign last_edge  = edge_stb && (edge_idx == EW'(EDGES - 1));
    assign sample_now = clk_pha ? edge_idx[0] : ~edge_idx[0];
    assign shift_now  = clk_pha ? (~edge_idx[0] && (edge_idx != '0)) : edge_idx[0];
    assign rx_word    = sample_now ? {rx_sr[DATA_W-2:0], miso} : rx_sr;
    assign mosi       = tx_sr[DATA_W-1];

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        load_byte = 1'b0;
        rx_push   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_en && !tx_empty) begin
                    state_d   = ST_LEAD;
                    load_byte = 1'b1;
                end
            end
            ST_LEAD: begin
                if (gap_cnt_q == '0) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (last_edge) begin
                    rx_push = 1'b1;
                    if (xfer_en && !tx_empty) begin
                        state_d   = ST_GAP;
                        load_byte = 1'b1;
                    end else begin
                        state_d = ST_TRAIL;
                    end
                end
            end
            ST_GAP: begin
                if (gap_cnt_q == '0) state_d = ST_SHIFT;
            end
            ST_TRAIL: begin
                if (gap_cnt_q == '0) state_d = ST_DESEL;
            end
            ST_DESEL: begin
                if (gap_cnt_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_LEAD:  gap_load = g_lead;
            ST_GAP:   gap_load = g_space;
            ST_TRAIL: gap_load = g_hold;
            ST_DESEL: gap_load = g_desel;
            default:  gap_load = '0;
        endcase
    end

    // State register and gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            gap_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                gap_cnt_q <= gap_load;
            end else if (gap_cnt_q != '0) begin
                gap_cnt_q <= gap_cnt_q - 1'b1;
            end
        end
    end

    // Output decode per state
    always_comb begin
        cs_active = 1'b0;
        clk_run   = 1'b0;
        unique case (state_q)
            ST_LEAD, ST_GAP, ST_TRAIL: cs_active = 1'b1;
            ST_SHIFT: begin
                cs_active = 1'b1;
                clk_run   = 1'b1;
            end
            default: begin
                cs_active = 1'b0;
                clk_run   = 1'b0;
            end
        endcase
    end

    // Shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load_byte) begin
            tx_sr <= tx_head;
            rx_sr <= '0;
        end else if (state_q == ST_SHIFT && edge_stb) begin
            if (sample_now) rx_sr <= rx_word;
            if (shift_now)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    // Lowest zero bit of the chip-select code picks the slave
    assign any_slave = ~&cs_field;

    for (genvar i = 0; i < NUM_SS; i++) begin : g_sel
        if (i == 0) begin : g_first
            assign slave_hit[i] = ~cs_field[0];
        end else begin : g_rest
            assign slave_hit[i] = ~cs_field[i] & (&cs_field[i-1:0]);
        end
        assign ss_n[i] = ~(cs_active && any_slave && slave_hit[i]);
    end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
`timescale 1ns/1ps
module spi_xfer_engine_chk
    import spi_xfer_pkg::*;
#(
    parameter int NUM_SS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_pol,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic              tx_full,
    input logic              tx_load,
    input logic              edge_stb,
    input logic              rx_push,
    input xfer_state_t       state_q
);
    assert_one_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_DESEL) |-> (sclk == clk_pol));

    assert_min_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |=> !edge_stb);

    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_load) |=> tx_full);

    assert_rx_per_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SHIFT && state_q != ST_SHIFT) |-> $past(rx_push));

    assert_select_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> $stable(ss_n));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.NUM_SS(NUM_SS)) chk_i (
    .clk(clk), .rst_n(rst_n), .clk_pol(clk_pol), .sclk(sclk), .ss_n(ss_n),
    .tx_full(tx_full), .tx_load(load_byte), .edge_stb(edge_stb),
    .rx_push(rx_push), .state_q(state_q)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_en = 1'b0, clk_pol = 1'b0, clk_pha = 1'b0;
    logic [2:0]  baud_sel = 3'd1;
    logic [3:0]  cs_field = 4'hF;
    logic [31:0] gap_cfg = '0;
    logic        tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        tx_full, tx_empty, rx_empty, rx_full, sclk, mosi;
    logic [7:0]  rx_dout;
    logic [2:0]  ss_n;

    always #2.5 clk = ~clk;

    spi_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .clk_pol(clk_pol),
        .clk_pha(clk_pha), .baud_sel(baud_sel), .cs_field(cs_field),
        .gap_cfg(gap_cfg), .tx_push(tx_push), .tx_byte(tx_byte),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_dout(rx_dout), .rx_empty(rx_empty), .rx_full(rx_full),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int checks = 0, fails = 0, cyc = 0;
    int edge_t[$], fall_t[$], rise_t[$];
    logic [7:0] exp_tx[$], got_tx[$], exp_rx[$];
    int  exp_sel = 0;
    bit  chk_idle = 1'b1;
    int  slave_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] resp_of(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural slave and bus monitor, sampled 1 ns after each edge
    logic       tgl_prev = 1'b0, mosi_prev = 1'b0, sel_prev = 1'b0;
    int         ein = 0, kbyte = 0;
    logic [7:0] sh, cap = '0;
    initial begin
        sh = resp_of(0);
        miso = sh[7];
    end

    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (&ss_n && chk_idle) chk(sclk == clk_pol, "R4", "idle sclk level", sclk, clk_pol);
            if ((sclk ^ clk_pol) != tgl_prev) begin
                edge_t.push_back(cyc);
                if (clk_pha ? (ein % 2 == 1) : (ein % 2 == 0)) cap = {cap[6:0], mosi_prev};
                if (clk_pha ? (ein % 2 == 0 && ein != 0) : (ein % 2 == 1)) sh = {sh[6:0], 1'b0};
                ein++;
                if (ein == 16) begin
                    got_tx.push_back(cap);
                    exp_rx.push_back(resp_of(kbyte));
                    slave_cnt++;
                    kbyte++;
                    ein = 0;
                    sh = resp_of(kbyte);
                end
                miso = sh[7];
            end
            if (~&ss_n && !sel_prev) begin
                fall_t.push_back(cyc);
                chk(exp_sel >= 0 && ss_n == ~(3'b001 << exp_sel), "R6", "selected line",
                    int'(ss_n), exp_sel);
            end
            if (&ss_n && sel_prev) rise_t.push_back(cyc);
            sel_prev = ~&ss_n;
            tgl_prev = sclk ^ clk_pol;
            mosi_prev = mosi;
        end
    end

    task automatic setup(input bit pol, input bit pha, input logic [2:0] b, input logic [3:0] cs,
                         input int sel, input logic [7:0] ld, input logic [7:0] sp,
                         input logic [7:0] hd, input logic [7:0] ds);
        @(negedge clk);
        xfer_en = 1'b0;
        clk_pol = pol; clk_pha = pha; baud_sel = b; cs_field = cs;
        gap_cfg = {ds, sp, hd, ld};
        exp_sel = sel;
        edge_t.delete(); fall_t.delete(); rise_t.delete();
    endtask

    task automatic push_tx(input logic [7:0] b, input bit record);
        @(negedge clk);
        tx_push = 1'b1; tx_byte = b;
        @(negedge clk);
        tx_push = 1'b0;
        if (record) exp_tx.push_back(b);
    endtask

    task automatic wait_bytes(input int n);
        while (slave_cnt < n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        while (got_tx.size() > 0 && exp_tx.size() > 0) begin
            logic [7:0] g, e;
            g = got_tx.pop_front(); e = exp_tx.pop_front();
            chk(g == e, "R1", {tag, " mosi byte"}, g, e);
        end
        chk(got_tx.size() == 0 && exp_tx.size() == 0, "R1", {tag, " tx leftovers"},
            got_tx.size(), exp_tx.size());
        forever begin
            @(negedge clk);
            if (rx_empty) break;
            if (exp_rx.size() == 0) begin
                chk(1'b0, "R1", {tag, " extra rx byte"}, rx_dout, -1);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                chk(rx_dout == e, "R1", {tag, " rx byte"}, rx_dout, e);
            end
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        chk(exp_rx.size() == 0, "R1", {tag, " rx count"}, exp_rx.size(), 0);
        exp_rx.delete();
    endtask

    task automatic chk_timing(input string tag, input int n, input int h, input int ld,
                              input int sp, input int hd, input bit sel);
        chk(edge_t.size() == 16 * n, "R4", {tag, " edge count"}, edge_t.size(), 16 * n);
        if (edge_t.size() != 16 * n) return;
        for (int b = 0; b < n; b++) begin
            int bad = 0;
            for (int i = 1; i < 16; i++)
                if (edge_t[16*b+i] - edge_t[16*b+i-1] != h) bad++;
            chk(bad == 0, "R3", {tag, " half period mismatches"}, bad, 0);
            if (b > 0)
                chk(edge_t[16*b] - edge_t[16*b-1] == sp + 1 + h, "R8", {tag, " byte spacing"},
                    edge_t[16*b] - edge_t[16*b-1], sp + 1 + h);
        end
        if (sel) begin
            chk(fall_t.size() == 1 && rise_t.size() == 1, "R8", {tag, " select pulses"},
                fall_t.size(), 1);
            if (fall_t.size() == 1 && rise_t.size() == 1) begin
                chk(edge_t[0] - fall_t[0] == ld + 1 + h, "R7", {tag, " setup gap"},
                    edge_t[0] - fall_t[0], ld + 1 + h);
                chk(rise_t[0] - edge_t[16*n-1] == hd + 1, "R9", {tag, " hold gap"},
                    rise_t[0] - edge_t[16*n-1], hd + 1);
            end
        end else begin
            chk(fall_t.size() == 0, "R6", {tag, " no select"}, fall_t.size(), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual %0d expected below 200000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == 3'b111, "R6", "reset ss_n", ss_n, 7);
        chk(sclk == 1'b0, "R4", "reset sclk", sclk, 0);
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R2", "reset queue flags",
            {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);

        // Mode 0, divider 4, slave 0
        setup(0, 0, 3'd1, 4'hE, 0, 8'd3, 8'd2, 8'd4, 8'd5);
        push_tx(8'hA5, 1); push_tx(8'h3C, 1); push_tx(8'h81, 1);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(3);
        repeat (20) @(negedge clk);
        chk_timing("mode0", 3, 2, 3, 2, 4, 1);
        drain("mode0 R5");

        // Mode 3, field 0 behaves as divider 4, slave 1
        setup(1, 1, 3'd0, 4'hD, 1, 8'd0, 8'd0, 8'd0, 8'd0);
        push_tx(8'h5A, 1); push_tx(8'hF0, 1);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(5);
        repeat (20) @(negedge clk);
        chk_timing("mode3", 2, 2, 0, 0, 0, 1);
        drain("mode3 R5");

        // Mode 1, divider 16, slave 2
        setup(0, 1, 3'd3, 4'hB, 2, 8'd7, 8'd9, 8'd1, 8'd2);
        push_tx(8'h01, 1); push_tx(8'hFE, 1);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(7);
        repeat (30) @(negedge clk);
        chk_timing("mode1", 2, 8, 7, 9, 1, 1);
        drain("mode1 R5");

        // Mode 2, divider 256, code with no addressable slave
        chk_idle = 1'b0;
        setup(1, 0, 3'd7, 4'h7, -1, 8'd1, 8'd1, 8'd1, 8'd1);
        push_tx(8'hC3, 1);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(8);
        repeat (20) @(negedge clk);
        chk_timing("mode2", 1, 128, 1, 1, 1, 0);
        drain("mode2 R5");
        chk_idle = 1'b1;

        // Deselect gap with a byte arriving during the hold gap
        setup(0, 0, 3'd1, 4'hE, 0, 8'd0, 8'd0, 8'd10, 8'd6);
        push_tx(8'h77, 1);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(9);
        repeat (2) @(negedge clk);
        push_tx(8'h88, 1);
        wait_bytes(10);
        repeat (20) @(negedge clk);
        chk(rise_t.size() == 2 && fall_t.size() == 2, "R10", "select pulses", fall_t.size(), 2);
        if (rise_t.size() >= 1 && fall_t.size() >= 2)
            chk(fall_t[1] - rise_t[0] == 6 + 2, "R10", "deselect gap",
                fall_t[1] - rise_t[0], 8);
        drain("desel");

        // Enable gating; code 0110 selects slave 0
        setup(0, 0, 3'd2, 4'h6, 0, 8'd0, 8'd0, 8'd0, 8'd0);
        push_tx(8'h12, 1); push_tx(8'h34, 1); push_tx(8'h56, 1);
        repeat (40) @(negedge clk);
        chk(edge_t.size() == 0 && fall_t.size() == 0, "R11", "no start while disabled",
            edge_t.size(), 0);
        @(negedge clk) xfer_en = 1'b1;
        while (edge_t.size() == 0) @(negedge clk);
        xfer_en = 1'b0;
        repeat (300) @(negedge clk);
        chk(slave_cnt == 11, "R11", "bytes after disable", slave_cnt, 11);
        chk(!tx_empty, "R11", "queued bytes kept", tx_empty, 0);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(13);
        repeat (20) @(negedge clk);
        drain("enable");

        // Full transmit queue; extra push discarded
        setup(0, 0, 3'd1, 4'hE, 0, 8'd0, 8'd0, 8'd0, 8'd0);
        for (int i = 0; i < 128; i++) push_tx(8'(i * 3 + 1), 1);
        @(negedge clk);
        chk(tx_full, "R2", "tx_full after 128", tx_full, 1);
        push_tx(8'hEE, 0);
        @(negedge clk) xfer_en = 1'b1;
        wait_bytes(141);
        repeat (40) @(negedge clk);
        chk(slave_cnt == 141, "R2", "no extra byte sent", slave_cnt, 141);
        chk(rx_full, "R2", "rx_full after 128", rx_full, 1);
        drain("full");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule